// File: doc/BRIEF.md
# Serial Command Slave with Control and Status Registers

This block is the host-facing end of a speech and data storage peripheral. A microcontroller frames each transaction with an active-low select line and clocks bytes in, most significant bit first, on the rising edge of its serial clock. The first byte of a frame is an opcode. The bytes after it carry either an argument, data for storage, or reply data sent back on the reply line. The serial clock, select and data inputs are synchronized into the system clock domain, and each bit is taken on a detected rising edge.

The block keeps a 16-bit control word and builds an 8-bit status byte from completion flags and a 5-bit power reading that come from the downstream engines. It drives an open-drain interrupt request. Store, play, write-data and read-data requests leave the block as one-cycle strobes with a 16-bit argument. Read data is fetched one byte at a time from the downstream engine through a request/return pair. The pad cells outside the block turn `replyDrive` into the tri-state enable of the reply pin and `irqDriveLow` into the pull-down of the shared interrupt line.

Top module: `serial_cmd_if`

## Requirements
- R1: After reset, and after opcode 0x01 in a frame, the control word is 0x0000, all status bits are 0, the interrupt is released, and `bufClear` pulses once for each 0x01 received.
- R2: Opcode 0x60 followed by two bytes loads the control word: the first byte goes to bits 15:8 and the second to bits 7:0. The word changes only after both bytes have been received.
- R3: Opcode 0x61 returns the status byte on the following byte slot, MSB first: bit 7 power reading ready, bit 6 store complete, bit 5 play complete, bits 4:0 the latest power level.
- R4: Completing a status read clears the power-ready bit and releases the interrupt. The store and play complete bits stay set.
- R5: `irqDriveLow` is 1 while an event not yet acknowledged has its enable bit set: control bit 10 for store complete, bit 9 for play complete, bit 8 for power ready. It is 0 when none of these is enabled.
- R6: Opcodes 0x62/0x63 (store) and 0x64/0x65 (play) pulse `storeCmd`/`playCmd` once, with `cmdArg` equal to the two following bytes (high byte first) and `cmdBuffered` equal to opcode bit 0. The command also clears the matching complete bit.
- R7: Opcode 0x66 pulses `writeStart` with the two-byte page in `cmdArg`, and every further byte in the frame is presented on `wrByte` with a one-cycle `wrByteValid`. Opcode 0x68 presents every byte after the opcode in the same way, with no argument.
- R8: Opcode 0x67 pulses `readStart` with its two-byte page. Opcode 0x69 takes no argument. Both then return, on each following byte slot, the `rdByte` value supplied in the cycle after each `rdByteReq` pulse, in order.
- R9: Select going high ends the frame. A partly received byte or a command with missing bytes has no effect, and the next frame decodes normally.
- R10: A pulse on `storeDone`, `playDone` or `powerValid` sets the matching status bit. `powerValid` also latches `powerLevel`.
- R11: `replyDrive` is 1 only inside a frame while reply bytes are due, and returns to 0 after select goes high.
- R12: A first byte that is not one of the listed opcodes produces no strobe and leaves the control word unchanged for the rest of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Host serial clock |
| csN | input | 1 | Active-low frame select |
| cmdData | input | 1 | Serial data from host, MSB first |
| storeDone | input | 1 | Store engine finished a command (pulse) |
| playDone | input | 1 | Play engine finished a command (pulse) |
| powerValid | input | 1 | New power reading available (pulse) |
| powerLevel | input | 5 | Power reading |
| rdByte | input | 8 | Byte returned for the last read request |
| replyData | output | 1 | Serial reply bit |
| replyDrive | output | 1 | Enable for the reply pad driver |
| irqDriveLow | output | 1 | Pull the shared interrupt line low |
| ctrlWord | output | 16 | Current control word |
| cmdArg | output | 16 | Argument of the last strobed command |
| cmdBuffered | output | 1 | Last store/play command was of the queued kind |
| storeCmd | output | 1 | Store command strobe |
| playCmd | output | 1 | Play command strobe |
| writeStart | output | 1 | Write-data start strobe |
| readStart | output | 1 | Read-data start strobe |
| wrByteValid | output | 1 | Data byte for storage valid |
| wrByte | output | 8 | Data byte for storage |
| rdByteReq | output | 1 | Request for the next read byte |
| bufClear | output | 1 | Empty downstream command buffers |

## Verification
The bench builds the block with the default two-stage synchronizer and drives the serial clock at one sixteenth of the system clock. This makes the delay from each host edge to its detected edge fixed and short compared with a half bit, so reply bits can be sampled just before each rising edge and every strobe has settled before select rises. The default depth also keeps the reply prefetch (request, one cycle of return, load) inside the gap between the last bit of one byte and the first bit of the next. Interrupt masking, flag clearing, aborted frames and both read and write streaming are driven directly. Random control words, arguments and data bytes are mixed in.

// File: rtl/sci_pkg.sv
package sci_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [BYTE_W-1:0] {
    OP_RESET    = 8'h01,
    OP_CTRL     = 8'h60,
    OP_STATUS   = 8'h61,
    OP_STORE_I  = 8'h62,
    OP_STORE_B  = 8'h63,
    OP_PLAY_I   = 8'h64,
    OP_PLAY_B   = 8'h65,
    OP_WR_START = 8'h66,
    OP_RD_START = 8'h67,
    OP_WR_CONT  = 8'h68,
    OP_RD_CONT  = 8'h69
  } opcode_e;

  // datapath -> control
  typedef struct packed {
    logic              byteDone;
    logic              csActive;
    logic [BYTE_W-1:0] rxByte;
  } rxInfo_t;

  // control -> datapath
  typedef struct packed {
    logic              load;
    logic [BYTE_W-1:0] data;
  } replyCtl_t;
endpackage

// File: rtl/sci_datapath.sv
module sci_datapath
  import sci_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclk,
  input  logic      csN,
  input  logic      cmdData,
  input  replyCtl_t replyCtl,
  output rxInfo_t   rxInfo,
  output logic      replyBit
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [SYNC_DEPTH:0]   sclkPipe;
  logic [SYNC_DEPTH-1:0] csPipe;
  logic [SYNC_DEPTH-1:0] dataPipe;
  logic [CNT_W-1:0]      bitCnt;
  logic [BYTE_W-1:0]     shiftIn;
  logic [BYTE_W-1:0]     shiftOut;
  logic                  csActive;
  logic                  shiftEn;
  logic                  dataBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      dataPipe <= '0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_DEPTH-1:0], sclk};
      csPipe   <= {csPipe[SYNC_DEPTH-2:0], csN};
      dataPipe <= {dataPipe[SYNC_DEPTH-2:0], cmdData};
    end
  end

  assign csActive = ~csPipe[SYNC_DEPTH-1];
  assign dataBit  = dataPipe[SYNC_DEPTH-1];
  assign shiftEn  = csActive & sclkPipe[SYNC_DEPTH-1] & ~sclkPipe[SYNC_DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      shiftIn <= '0;
    end else if (!csActive) begin
      bitCnt <= '0;
    end else if (shiftEn) begin
      shiftIn <= {shiftIn[BYTE_W-2:0], dataBit};
      bitCnt  <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftOut <= '0;
    else if (replyCtl.load)  shiftOut <= replyCtl.data;
    else if (shiftEn)        shiftOut <= {shiftOut[BYTE_W-2:0], 1'b0};
  end

  assign rxInfo.byteDone = shiftEn && (bitCnt == CNT_W'(BYTE_W - 1));
  assign rxInfo.csActive = csActive;
  assign rxInfo.rxByte   = {shiftIn[BYTE_W-2:0], dataBit};
  assign replyBit        = shiftOut[BYTE_W-1];

  // R9: a closed frame leaves no partial byte behind
  a_r9_abort_clears_bits: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> (bitCnt == '0));
  // R3: bits advance only on a detected rising edge inside a frame
  a_r3_bits_need_edge: assert property (@(posedge clk) disable iff (!rstN)
    !shiftEn |=> $stable(bitCnt) || (bitCnt == '0));
endmodule

// File: rtl/sci_control.sv
module sci_control
  import sci_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rxInfo_t           rxInfo,
  input  logic              storeDone,
  input  logic              playDone,
  input  logic              powerValid,
  input  logic [4:0]        powerLevel,
  input  logic [BYTE_W-1:0] rdByte,
  output replyCtl_t         replyCtl,
  output logic [15:0]       ctrlWord,
  output logic [15:0]       cmdArg,
  output logic              cmdBuffered,
  output logic              storeCmd,
  output logic              playCmd,
  output logic              writeStart,
  output logic              readStart,
  output logic              wrByteValid,
  output logic [BYTE_W-1:0] wrByte,
  output logic              rdByteReq,
  output logic              bufClear,
  output logic              irqDriveLow,
  output logic              replyDrive
);
  logic [BYTE_W-1:0] opcode, argHi;
  logic [1:0]        byteIdx;
  logic [15:0]       ctrlReg;
  logic              pwrRdy, stDone, plDone, reqDly;
  logic [4:0]        level;
  logic [2:0]        pend;     // {store, play, power}
  logic              isWrData, isRdData, statusByteDone;
  logic [BYTE_W-1:0] rx;

  assign rx       = rxInfo.rxByte;
  assign isWrData = (opcode == OP_WR_CONT && byteIdx != 2'd0) ||
                    (opcode == OP_WR_START && byteIdx == 2'd3);
  assign isRdData = (opcode == OP_RD_CONT && byteIdx != 2'd0) ||
                    (opcode == OP_RD_START && byteIdx == 2'd3);
  assign statusByteDone = rxInfo.byteDone && byteIdx == 2'd1 && opcode == OP_STATUS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcode <= '0; argHi <= '0; byteIdx <= '0; ctrlReg <= '0;
      pwrRdy <= 1'b0; stDone <= 1'b0; plDone <= 1'b0; level <= '0; pend <= '0;
      reqDly <= 1'b0; cmdArg <= '0; cmdBuffered <= 1'b0; wrByte <= '0;
      storeCmd <= 1'b0; playCmd <= 1'b0; writeStart <= 1'b0; readStart <= 1'b0;
      wrByteValid <= 1'b0; rdByteReq <= 1'b0; bufClear <= 1'b0; replyDrive <= 1'b0;
    end else begin
      storeCmd <= 1'b0; playCmd <= 1'b0; writeStart <= 1'b0; readStart <= 1'b0;
      wrByteValid <= 1'b0; rdByteReq <= 1'b0; bufClear <= 1'b0;
      reqDly <= rdByteReq;
      if (storeDone)  begin stDone <= 1'b1; pend[2] <= 1'b1; end
      if (playDone)   begin plDone <= 1'b1; pend[1] <= 1'b1; end
      if (powerValid) begin pwrRdy <= 1'b1; pend[0] <= 1'b1; level <= powerLevel; end
      if (!rxInfo.csActive) begin
        byteIdx    <= '0;
        replyDrive <= 1'b0;
      end else if (rxInfo.byteDone) begin
        byteIdx <= (byteIdx == 2'd3) ? 2'd3 : byteIdx + 2'd1;
        if (byteIdx == 2'd0) begin
          opcode <= rx;
          case (rx)
            OP_RESET: begin
              ctrlReg <= '0; stDone <= 1'b0; plDone <= 1'b0; pwrRdy <= 1'b0;
              level <= '0; pend <= '0; bufClear <= 1'b1;
            end
            OP_STATUS:  replyDrive <= 1'b1;
            OP_RD_CONT: begin rdByteReq <= 1'b1; replyDrive <= 1'b1; end
            default: ;
          endcase
        end else begin
          if (byteIdx == 2'd1) argHi <= rx;
          if (statusByteDone) begin
            pwrRdy <= 1'b0; pend <= '0; replyDrive <= 1'b0;
          end
          if (byteIdx == 2'd2) begin
            case (opcode)
              OP_CTRL: ctrlReg <= {argHi, rx};
              OP_STORE_I, OP_STORE_B: begin
                cmdArg <= {argHi, rx}; cmdBuffered <= opcode[0]; storeCmd <= 1'b1;
                stDone <= 1'b0; pend[2] <= 1'b0;
              end
              OP_PLAY_I, OP_PLAY_B: begin
                cmdArg <= {argHi, rx}; cmdBuffered <= opcode[0]; playCmd <= 1'b1;
                plDone <= 1'b0; pend[1] <= 1'b0;
              end
              OP_WR_START: begin cmdArg <= {argHi, rx}; writeStart <= 1'b1; end
              OP_RD_START: begin
                cmdArg <= {argHi, rx}; readStart <= 1'b1;
                rdByteReq <= 1'b1; replyDrive <= 1'b1;
              end
              default: ;
            endcase
          end
          if (isWrData) begin wrByteValid <= 1'b1; wrByte <= rx; end
          if (isRdData) rdByteReq <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    replyCtl = '0;
    if (rxInfo.byteDone && byteIdx == 2'd0 && rx == OP_STATUS) begin
      replyCtl.load = 1'b1;
      replyCtl.data = {pwrRdy, stDone, plDone, level};
    end else if (reqDly) begin
      replyCtl.load = 1'b1;
      replyCtl.data = rdByte;
    end
  end

  assign ctrlWord    = ctrlReg;
  assign irqDriveLow = |(pend & ctrlReg[10:8]);

  // R1: the reset opcode leaves registers cleared and the line released
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rstN)
    bufClear |-> (ctrlReg == '0) && !irqDriveLow && !pwrRdy);
  // R2: the control word moves only on a completed byte
  a_r2_ctrl_on_byte: assert property (@(posedge clk) disable iff (!rstN)
    !rxInfo.byteDone |=> $stable(ctrlReg));
  // R4: a finished status read drops power-ready and the interrupt
  a_r4_status_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    statusByteDone |=> !pwrRdy && !irqDriveLow);
  // R5: no enable, no interrupt
  a_r5_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[10:8] == 3'b000) |-> !irqDriveLow);
  // R6: at most one request strobe per cycle
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({storeCmd, playCmd, writeStart, readStart, bufClear, wrByteValid}));
  // R11: reply driver released once the frame closes
  a_r11_reply_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    !rxInfo.csActive |=> !replyDrive);
endmodule

// File: rtl/serial_cmd_if.sv
module serial_cmd_if
  import sci_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclk,
  input  logic        csN,
  input  logic        cmdData,
  input  logic        storeDone,
  input  logic        playDone,
  input  logic        powerValid,
  input  logic [4:0]  powerLevel,
  input  logic [7:0]  rdByte,
  output logic        replyData,
  output logic        replyDrive,
  output logic        irqDriveLow,
  output logic [15:0] ctrlWord,
  output logic [15:0] cmdArg,
  output logic        cmdBuffered,
  output logic        storeCmd,
  output logic        playCmd,
  output logic        writeStart,
  output logic        readStart,
  output logic        wrByteValid,
  output logic [7:0]  wrByte,
  output logic        rdByteReq,
  output logic        bufClear
);
  rxInfo_t   rxInfo;
  replyCtl_t replyCtl;

  sci_datapath #(.SYNC_DEPTH(SYNC_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .cmdData(cmdData),
    .replyCtl(replyCtl), .rxInfo(rxInfo), .replyBit(replyData)
  );

  sci_control u_ctl (
    .clk(clk), .rstN(rstN), .rxInfo(rxInfo),
    .storeDone(storeDone), .playDone(playDone), .powerValid(powerValid),
    .powerLevel(powerLevel), .rdByte(rdByte), .replyCtl(replyCtl),
    .ctrlWord(ctrlWord), .cmdArg(cmdArg), .cmdBuffered(cmdBuffered),
    .storeCmd(storeCmd), .playCmd(playCmd), .writeStart(writeStart),
    .readStart(readStart), .wrByteValid(wrByteValid), .wrByte(wrByte),
    .rdByteReq(rdByteReq), .bufClear(bufClear), .irqDriveLow(irqDriveLow),
    .replyDrive(replyDrive)
  );
endmodule

// File: tb/serial_cmd_if_test.sv
module serial_cmd_if_test;
  localparam int HALF = 8;

  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, csN = 1'b1, cmdData = 1'b0;
  logic storeDone = 1'b0, playDone = 1'b0, powerValid = 1'b0;
  logic [4:0] powerLevel = '0;
  logic [7:0] rdByte = '0;
  logic replyData, replyDrive, irqDriveLow, cmdBuffered, storeCmd, playCmd;
  logic writeStart, readStart, wrByteValid, rdByteReq, bufClear;
  logic [15:0] ctrlWord, cmdArg;
  logic [7:0] wrByte;

  serial_cmd_if uut (.*);

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  int storeCnt = 0, playCnt = 0, wsCnt = 0, rsCnt = 0, clrCnt = 0, wrCnt = 0;
  logic [15:0] lastArg = '0;
  logic lastBuf = 1'b0;
  logic [7:0] wrLog [0:63];
  logic [7:0] rdNext = 8'h30;
  logic [7:0] txBuf [0:15];
  logic [7:0] rxBuf [0:15];
  logic rxDrv [0:15];

  always @(posedge clk) begin
    if (storeCmd)   begin storeCnt <= storeCnt + 1; lastArg <= cmdArg; lastBuf <= cmdBuffered; end
    if (playCmd)    begin playCnt <= playCnt + 1; lastArg <= cmdArg; lastBuf <= cmdBuffered; end
    if (writeStart) begin wsCnt <= wsCnt + 1; lastArg <= cmdArg; end
    if (readStart)  begin rsCnt <= rsCnt + 1; lastArg <= cmdArg; end
    if (bufClear)   clrCnt <= clrCnt + 1;
    if (wrByteValid) begin wrLog[wrCnt % 64] <= wrByte; wrCnt <= wrCnt + 1; end
    if (rdByteReq)  begin rdByte <= rdNext; rdNext <= rdNext + 8'd7; end
  end

  function automatic logic [7:0] expStatus(input logic p, input logic s, input logic q,
                                           input logic [4:0] lv);
    return {p, s, q, lv};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int n);
    waitClk(1);
    csN = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < n; i++) begin
      logic [7:0] r;
      r = '0;
      for (int b = 7; b >= 0; b--) begin
        cmdData = txBuf[i][b];
        waitClk(HALF);
        r[b] = replyData;
        if (b == 7) rxDrv[i] = replyDrive;
        sclk = 1'b1;
        waitClk(HALF);
        sclk = 1'b0;
      end
      rxBuf[i] = r;
    end
    waitClk(HALF);
    csN = 1'b1;
    waitClk(HALF);
  endtask

  task automatic writeCtrl(input logic [15:0] v);
    txBuf[0] = 8'h60; txBuf[1] = v[15:8]; txBuf[2] = v[7:0];
    frame(3);
  endtask

  task automatic readStatus(output logic [7:0] s);
    txBuf[0] = 8'h61; txBuf[1] = 8'h00;
    frame(2);
    s = rxBuf[1];
  endtask

  task automatic pulseStore(); waitClk(1); storeDone = 1'b1; waitClk(1); storeDone = 1'b0; waitClk(2); endtask
  task automatic pulsePlay();  waitClk(1); playDone = 1'b1;  waitClk(1); playDone = 1'b0;  waitClk(2); endtask
  task automatic pulsePower(input logic [4:0] lv);
    waitClk(1); powerLevel = lv; powerValid = 1'b1; waitClk(1); powerValid = 1'b0; waitClk(2);
  endtask

  logic finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] st;
    logic [15:0] v;
    int base, sc;
    logic [7:0] b0;
    void'($urandom(32'd2024));
    waitClk(5); rstN = 1'b1; waitClk(5);

    // R1 reset state
    check("R1 ctrl after reset", ctrlWord, 16'h0);
    check("R1 irq after reset", irqDriveLow, 1'b0);
    check("R11 no drive idle", replyDrive, 1'b0);
    readStatus(st);
    check("R1 status after reset", st, 8'h00);
    check("R11 drive during reply", rxDrv[1], 1'b1);
    check("R11 drive released", replyDrive, 1'b0);

    // R2 random control words
    for (int k = 0; k < 6; k++) begin
      v = 16'($urandom) & 16'hF8FF;
      writeCtrl(v);
      check("R2 ctrl write", ctrlWord, v);
    end
    writeCtrl(16'h1234);
    // R2 / R9 command missing its second byte
    txBuf[0] = 8'h60; txBuf[1] = 8'hAB;
    frame(2);
    check("R2 incomplete ctrl ignored", ctrlWord, 16'h1234);
    // R9 partial byte then select high
    waitClk(1); csN = 1'b0; waitClk(HALF);
    for (int b = 0; b < 3; b++) begin
      cmdData = 1'b1; waitClk(HALF); sclk = 1'b1; waitClk(HALF); sclk = 1'b0;
    end
    waitClk(HALF); csN = 1'b1; waitClk(HALF);
    writeCtrl(16'h4321);
    check("R9 decode after abort", ctrlWord, 16'h4321);

    // R12 unknown opcode
    sc = storeCnt + playCnt + wsCnt + rsCnt + clrCnt + wrCnt;
    txBuf[0] = 8'h7A; txBuf[1] = 8'h11; txBuf[2] = 8'h22; txBuf[3] = 8'h33;
    frame(4);
    check("R12 ctrl unchanged", ctrlWord, 16'h4321);
    check("R12 no strobes", storeCnt + playCnt + wsCnt + rsCnt + clrCnt + wrCnt, sc);

    // R5 / R10 / R3 / R4 interrupt and status
    writeCtrl(16'h0700);
    pulsePower(5'h15);
    pulseStore();
    check("R5 irq enabled", irqDriveLow, 1'b1);
    readStatus(st);
    check("R3 R10 status layout", st, expStatus(1, 1, 0, 5'h15));
    check("R4 irq released", irqDriveLow, 1'b0);
    readStatus(st);
    check("R4 power ready cleared", st, expStatus(0, 1, 0, 5'h15));
    writeCtrl(16'h0000);
    pulsePlay();
    check("R5 irq masked", irqDriveLow, 1'b0);
    readStatus(st);
    check("R10 play flag", st, expStatus(0, 1, 1, 5'h15));

    // R6 store and play
    txBuf[0] = 8'h63; txBuf[1] = 8'h12; txBuf[2] = 8'h34; frame(3);
    check("R6 store count", storeCnt, 1);
    check("R6 store arg", lastArg, 16'h1234);
    check("R6 store queued", lastBuf, 1'b1);
    readStatus(st);
    check("R6 store flag cleared", st, expStatus(0, 0, 1, 5'h15));
    txBuf[0] = 8'h64; txBuf[1] = 8'h05; txBuf[2] = 8'h67; frame(3);
    check("R6 play count", playCnt, 1);
    check("R6 play arg", lastArg, 16'h0567);
    check("R6 play immediate", lastBuf, 1'b0);
    readStatus(st);
    check("R6 play flag cleared", st, expStatus(0, 0, 0, 5'h15));
    for (int k = 0; k < 4; k++) begin
      logic [7:0] op;
      op = 8'h62 + 8'($urandom % 4);
      v = 16'($urandom);
      sc = storeCnt + playCnt;
      txBuf[0] = op; txBuf[1] = v[15:8]; txBuf[2] = v[7:0]; frame(3);
      check("R6 random count", storeCnt + playCnt, sc + 1);
      check("R6 random arg", lastArg, v);
      check("R6 random queued", lastBuf, op[0]);
    end

    // R7 write data
    base = wrCnt;
    txBuf[0] = 8'h66; txBuf[1] = 8'hBE; txBuf[2] = 8'hEF;
    for (int k = 3; k < 6; k++) txBuf[k] = 8'($urandom);
    frame(6);
    check("R7 write start", wsCnt, 1);
    check("R7 write page", lastArg, 16'hBEEF);
    check("R7 write count", wrCnt - base, 3);
    for (int k = 0; k < 3; k++) check("R7 write byte", wrLog[(base + k) % 64], txBuf[3 + k]);
    base = wrCnt;
    txBuf[0] = 8'h68; txBuf[1] = 8'h5A; txBuf[2] = 8'hC3;
    frame(3);
    check("R7 continue count", wrCnt - base, 2);
    check("R7 continue byte0", wrLog[base % 64], 8'h5A);
    check("R7 continue byte1", wrLog[(base + 1) % 64], 8'hC3);

    // R8 read data
    b0 = rdNext;
    txBuf[0] = 8'h67; txBuf[1] = 8'h01; txBuf[2] = 8'h02;
    for (int k = 3; k < 6; k++) txBuf[k] = 8'h00;
    frame(6);
    check("R8 read start", rsCnt, 1);
    check("R8 read page", lastArg, 16'h0102);
    for (int k = 0; k < 3; k++) check("R8 read byte", rxBuf[3 + k], 8'(b0 + 8'(7 * k)));
    check("R11 drive on read", rxDrv[3], 1'b1);
    b0 = rdNext;
    txBuf[0] = 8'h69; txBuf[1] = 8'h00; txBuf[2] = 8'h00;
    frame(3);
    check("R8 continue byte0", rxBuf[1], b0);
    check("R8 continue byte1", rxBuf[2], 8'(b0 + 8'd7));
    check("R11 released after read", replyDrive, 1'b0);

    // R1 general reset opcode
    writeCtrl(16'h07F0);
    pulseStore();
    check("R5 irq before reset", irqDriveLow, 1'b1);
    txBuf[0] = 8'h01; frame(1);
    check("R1 ctrl cleared", ctrlWord, 16'h0);
    check("R1 irq released", irqDriveLow, 1'b0);
    check("R1 buffer clear pulse", clrCnt, 1);
    readStatus(st);
    check("R1 status cleared", st, 8'h00);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule